// File: doc/BRIEF.md
# Burst-of-two DDR SRAM controller

This block is the host-side controller for a synchronous double-data-rate SRAM that has separate write-data and read-data buses and one shared command port. On the host side it takes one request per cycle through a valid/ready handshake. A request carries a read/write flag, an address, two data words and per-byte enables for each word. Each accepted request becomes one cycle on the memory command port: an active-low load strobe, a read/write select and the address.

Every command moves exactly two words. On a write, both words and their active-low byte masks go out in the same core cycle as the command. The first word is the beat for the rising edge of the main clock, and the second word is the beat for the inverted clock. On a read, the device returns a pair of words a fixed number of cycles later. The controller tracks each read in flight with a shift register, captures the pair at the right cycle, and presents it with a valid flag. When no request is pending, the load strobe stays high, which makes the cycle a no-operation for the device.

Pad timing and the memory array are not part of this block. The two clock phases are modelled as two parallel beats per core clock.

Top module: `ddrs_ctrl`

## Requirements
- R1: While `rst` is high, `req_ready` is 0, `mem_ld_n` is 1 and `rd_valid` is 0.
- R2: In a cycle that follows a clock edge at which no request was accepted, `mem_ld_n` is 1 (no-operation), whatever `req_addr` and `req_write` hold.
- R3: A request accepted at a clock edge appears on the command port in the next cycle: `mem_ld_n` = 0, `mem_rw` = 1 for a read and 0 for a write (`req_write` = 1 means write), and `mem_addr` equal to `req_addr`.
- R4: For an accepted write, `mem_d_rise` carries `req_wdata0` (first beat) and `mem_d_fall` carries `req_wdata1` (second beat), in the same cycle as the write command.
- R5: Byte masks are active low and independent per beat. Bit b of `mem_bw_rise_n` is the inverse of bit b of `req_ben0`, and bit b of `mem_bw_fall_n` is the inverse of bit b of `req_ben1`. Byte b covers data bits [9b+8:9b]. In no-operation cycles both masks are all ones.
- R6: Out of reset `req_ready` is 1 on every cycle, and requests are accepted one per cycle with no idle cycle between them, including a read followed directly by a write.
- R7: The device presents a read pair `RD_LAT` cycles after the read command cycle. The controller raises `rd_valid` for one cycle in the following cycle, with `rd_data0` taken from `mem_q_first` (first word) and `rd_data1` from `mem_q_second` (second word).
- R8: Reset clears read tracking. A read whose command was issued before reset asserts never produces `rd_valid`.
- R9: Read results are returned in command order, one pair for each read, with no extra results. Written bytes read back with the new value and masked bytes keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (main clock K) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Burst address |
| req_wdata0 | input | NBYTES*BYTE_W | First write word |
| req_wdata1 | input | NBYTES*BYTE_W | Second write word |
| req_ben0 | input | NBYTES | Active-high byte enables, first word |
| req_ben1 | input | NBYTES | Active-high byte enables, second word |
| rd_valid | output | 1 | Read pair valid |
| rd_data0 | output | NBYTES*BYTE_W | First word of read pair |
| rd_data1 | output | NBYTES*BYTE_W | Second word of read pair |
| mem_ld_n | output | 1 | Active-low load strobe; high = no-operation |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | ADDR_W | Command address |
| mem_d_rise | output | NBYTES*BYTE_W | Write beat for the rising edge of K |
| mem_d_fall | output | NBYTES*BYTE_W | Write beat for the rising edge of K# |
| mem_bw_rise_n | output | NBYTES | Active-low byte masks, first beat |
| mem_bw_fall_n | output | NBYTES | Active-low byte masks, second beat |
| mem_q_first | input | NBYTES*BYTE_W | Returned first word (C# referenced) |
| mem_q_second | input | NBYTES*BYTE_W | Returned second word (C referenced) |

## Verification
The bench targets read-capture timing. The device model drives a garbage pattern in every cycle except the exact data cycle, so a controller that captures one cycle early or late returns wrong words. Its latency check also catches a shifted `rd_valid`. Mixed per-beat masks are written and read back, so a design that swaps beats, inverts polarity or shares one mask for both beats leaves wrong bytes in memory. A continuous write-read-write-read stream tests the no-bubble handshake and the ordering of results. A read cut off by reset tests that stale tracking never yields a phantom `rd_valid`.

// File: rtl/ddrs_pkg.sv
package ddrs_pkg;
    localparam int DEF_ADDR_W = 20;
    localparam int DEF_NBYTES = 4;
    localparam int DEF_BYTE_W = 9;
    localparam int DEF_RD_LAT = 2;

    // Encoding of the read/write select on the memory command port
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } mem_dir_e;

    function automatic mem_dir_e dir_of(input logic is_write);
        return is_write ? DIR_WRITE : DIR_READ;
    endfunction
endpackage

// File: rtl/ddrs_byte_mask.sv
module ddrs_byte_mask #(
    parameter int NBYTES = 4
) (
    input  logic              fire,
    input  logic [NBYTES-1:0] ben,
    output logic [NBYTES-1:0] mask_n
);
    // One lane per byte: active-low mask, forced high when nothing is issued
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign mask_n[b] = ~(fire & ben[b]);
    end
endmodule

// File: rtl/ddrs_cmd_issue.sv
module ddrs_cmd_issue
    import ddrs_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NBYTES = DEF_NBYTES,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata0,
    input  logic [DATA_W-1:0] req_wdata1,
    input  logic [NBYTES-1:0] req_ben0,
    input  logic [NBYTES-1:0] req_ben1,
    output logic              mem_ld_n,
    output mem_dir_e          mem_dir,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_d_rise,
    output logic [DATA_W-1:0] mem_d_fall,
    output logic [NBYTES-1:0] mem_bw_rise_n,
    output logic [NBYTES-1:0] mem_bw_fall_n
);
    logic              fire;
    logic              wr_fire;
    logic [NBYTES-1:0] nxt_rise_n;
    logic [NBYTES-1:0] nxt_fall_n;

    assign req_ready = ~rst;
    assign fire      = req_valid & req_ready;
    assign wr_fire   = fire & req_write;

    ddrs_byte_mask #(.NBYTES(NBYTES)) u_mask_rise (
        .fire(wr_fire), .ben(req_ben0), .mask_n(nxt_rise_n)
    );
    ddrs_byte_mask #(.NBYTES(NBYTES)) u_mask_fall (
        .fire(wr_fire), .ben(req_ben1), .mask_n(nxt_fall_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ld_n      <= 1'b1;
            mem_dir       <= DIR_READ;
            mem_addr      <= '0;
            mem_d_rise    <= '0;
            mem_d_fall    <= '0;
            mem_bw_rise_n <= '1;
            mem_bw_fall_n <= '1;
        end else begin
            mem_ld_n      <= ~fire;
            mem_bw_rise_n <= nxt_rise_n;
            mem_bw_fall_n <= nxt_fall_n;
            if (fire) begin
                mem_dir    <= dir_of(req_write);
                mem_addr   <= req_addr;
                mem_d_rise <= req_wdata0;
                mem_d_fall <= req_wdata1;
            end
        end
    end

    // R2: no accepted request leaves the next cycle idle
    a_r2_idle_without_request: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> mem_ld_n);

    // R3: accepted request shows on the command port one cycle later
    a_r3_command_follows_request: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && !$past(rst)) |->
            (!mem_ld_n && (mem_dir == dir_of($past(req_write))) && (mem_addr == $past(req_addr))));

    // R5: idle cycles never carry an enabled byte
    a_r5_idle_masks_high: assert property (@(posedge clk) disable iff (rst)
        mem_ld_n |-> ((&mem_bw_rise_n) && (&mem_bw_fall_n)));

    // R6: always ready outside reset
    a_r6_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
        req_ready);
endmodule

// File: rtl/ddrs_rd_tracker.sv
module ddrs_rd_tracker #(
    parameter int DATA_W = 36,
    parameter int RD_LAT = 2,
    localparam int CNT_W = $clog2(RD_LAT + 2) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] mem_q_first,
    input  logic [DATA_W-1:0] mem_q_second,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1
);
    logic [RD_LAT-1:0] track;
    logic              capture;

    assign capture = track[RD_LAT-1];

    // Tracking shift register; bit k set means a read command was k+1 cycles ago
    if (RD_LAT == 1) begin : g_lat1
        always_ff @(posedge clk) begin
            if (rst) track <= '0;
            else     track <= issue_rd;
        end
    end else begin : g_latn
        always_ff @(posedge clk) begin
            if (rst) track <= '0;
            else     track <= {track[RD_LAT-2:0], issue_rd};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data0 <= '0;
            rd_data1 <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data0 <= mem_q_first;
                rd_data1 <= mem_q_second;
            end
        end
    end

    // Checker state: reads issued but not yet returned
    logic [CNT_W-1:0] in_flight;
    always_ff @(posedge clk) begin
        if (rst) in_flight <= '0;
        else     in_flight <= in_flight + CNT_W'(issue_rd) - CNT_W'(rd_valid);
    end

    // R7: a result never appears without a read outstanding
    a_r7_valid_needs_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (in_flight != '0));

    // R9: no more reads in flight than the pipeline can hold
    a_r9_in_flight_bounded: assert property (@(posedge clk) disable iff (rst)
        in_flight <= CNT_W'(RD_LAT + 1));

    // R8: first cycle after reset has no result
    a_r8_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid);
endmodule

// File: rtl/ddrs_ctrl.sv
module ddrs_ctrl
    import ddrs_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NBYTES = DEF_NBYTES,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int RD_LAT = DEF_RD_LAT,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata0,
    input  logic [DATA_W-1:0] req_wdata1,
    input  logic [NBYTES-1:0] req_ben0,
    input  logic [NBYTES-1:0] req_ben1,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic              mem_ld_n,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_d_rise,
    output logic [DATA_W-1:0] mem_d_fall,
    output logic [NBYTES-1:0] mem_bw_rise_n,
    output logic [NBYTES-1:0] mem_bw_fall_n,
    input  logic [DATA_W-1:0] mem_q_first,
    input  logic [DATA_W-1:0] mem_q_second
);
    mem_dir_e dir;
    logic     issue_rd;

    ddrs_cmd_issue #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_issue (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
        .req_ben0(req_ben0), .req_ben1(req_ben1),
        .mem_ld_n(mem_ld_n), .mem_dir(dir), .mem_addr(mem_addr),
        .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
        .mem_bw_rise_n(mem_bw_rise_n), .mem_bw_fall_n(mem_bw_fall_n)
    );

    assign mem_rw   = (dir == DIR_READ);
    assign issue_rd = ~mem_ld_n & (dir == DIR_READ);

    ddrs_rd_tracker #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_track (
        .clk(clk), .rst(rst), .issue_rd(issue_rd),
        .mem_q_first(mem_q_first), .mem_q_second(mem_q_second),
        .rd_valid(rd_valid), .rd_data0(rd_data0), .rd_data1(rd_data1)
    );
endmodule

// File: tb/ddrs_ctrl_bench.sv
module ddrs_ctrl_bench;
    localparam int AW  = 20;
    localparam int NB  = 4;
    localparam int BW  = 9;
    localparam int LAT = 2;
    localparam int DW  = NB * BW;
    localparam logic [DW-1:0] JUNK = 36'h5A5A5A5A5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata0 = '0, req_wdata1 = '0;
    logic [NB-1:0] req_ben0 = '0, req_ben1 = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data0, rd_data1;
    logic          mem_ld_n, mem_rw;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_d_rise, mem_d_fall, mem_q_first, mem_q_second;
    logic [NB-1:0] mem_bw_rise_n, mem_bw_fall_n;

    always #5 clk = ~clk;

    ddrs_ctrl #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW), .RD_LAT(LAT)) u_ddrs_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata0(req_wdata0),
        .req_wdata1(req_wdata1), .req_ben0(req_ben0), .req_ben1(req_ben1),
        .rd_valid(rd_valid), .rd_data0(rd_data0), .rd_data1(rd_data1),
        .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
        .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
        .mem_bw_rise_n(mem_bw_rise_n), .mem_bw_fall_n(mem_bw_fall_n),
        .mem_q_first(mem_q_first), .mem_q_second(mem_q_second)
    );

    // Behavioural device: 16 word pairs, reads return LAT cycles after the command cycle
    logic [DW-1:0] dev0 [16];
    logic [DW-1:0] dev1 [16];
    logic          pv   [LAT];
    logic [DW-1:0] pd0  [LAT];
    logic [DW-1:0] pd1  [LAT];
    initial begin
        for (int i = 0; i < 16; i++) begin dev0[i] = '0; dev1[i] = '0; end
        for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd0[i] = '0; pd1[i] = '0; end
    end
    always @(posedge clk) begin
        if (!mem_ld_n && !mem_rw)
            for (int b = 0; b < NB; b++) begin
                if (!mem_bw_rise_n[b]) dev0[mem_addr[3:0]][b*BW +: BW] <= mem_d_rise[b*BW +: BW];
                if (!mem_bw_fall_n[b]) dev1[mem_addr[3:0]][b*BW +: BW] <= mem_d_fall[b*BW +: BW];
            end
        for (int i = LAT - 1; i > 0; i--) begin
            pv[i] <= pv[i-1]; pd0[i] <= pd0[i-1]; pd1[i] <= pd1[i-1];
        end
        pv[0]  <= !mem_ld_n && mem_rw;
        pd0[0] <= dev0[mem_addr[3:0]];
        pd1[0] <= dev1[mem_addr[3:0]];
    end
    assign mem_q_first  = pv[LAT-1] ? pd0[LAT-1] : JUNK;
    assign mem_q_second = pv[LAT-1] ? pd1[LAT-1] : ~JUNK;

    // Independent shadow and expected-result queue
    logic [DW-1:0] sh0 [16];
    logic [DW-1:0] sh1 [16];
    logic [DW-1:0] ex0 [64];
    logic [DW-1:0] ex1 [64];
    int            exc [64];
    int wp = 0, rp = 0, cyc = 0, checks = 0, errors = 0;
    initial for (int i = 0; i < 16; i++) begin sh0[i] = '0; sh1[i] = '0; end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Result monitor (R7 timing and data, R9 order and count)
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (rp == wp) chk(1'b0, "R9", "unexpected rd_valid", 64'(cyc), 64'hFFFF);
            else begin
                chk(cyc == exc[rp], "R7", "rd_valid cycle", 64'(cyc), 64'(exc[rp]));
                chk(rd_data0 == ex0[rp], "R7", "rd_data0 first word", 64'(rd_data0), 64'(ex0[rp]));
                chk(rd_data1 == ex1[rp], "R7", "rd_data1 second word", 64'(rd_data1), 64'(ex1[rp]));
                rp++;
            end
        end
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d0,
                         input logic [DW-1:0] d1, input logic [NB-1:0] b0, input logic [NB-1:0] b1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata0 = d0; req_wdata1 = d1; req_ben0 = b0; req_ben1 = b1;
        if (wr) begin
            for (int b = 0; b < NB; b++) begin
                if (b0[b]) sh0[a[3:0]][b*BW +: BW] = d0[b*BW +: BW];
                if (b1[b]) sh1[a[3:0]][b*BW +: BW] = d1[b*BW +: BW];
            end
        end else begin
            ex0[wp] = sh0[a[3:0]]; ex1[wp] = sh1[a[3:0]]; exc[wp] = cyc + LAT + 2; wp++;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 4) @(negedge clk);
        chk(rp == wp, "R9", "all reads returned", 64'(rp), 64'(wp));
    endtask

    task automatic t_reset_state();
        req_valid = 1'b1; req_write = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R1", "req_ready in reset", 64'(req_ready), 0);
        chk(mem_ld_n == 1'b1, "R1", "mem_ld_n in reset", 64'(mem_ld_n), 1);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", 64'(rd_valid), 0);
        req_valid = 1'b0; rst = 1'b0;
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_addr = AW'(i * 7 + 1); req_write = i[0];
            chk(mem_ld_n == 1'b1, "R2", "idle load strobe", 64'(mem_ld_n), 1);
            chk(req_ready == 1'b1, "R6", "ready out of reset", 64'(req_ready), 1);
        end
    endtask

    task automatic t_write_pins();
        issue(1'b1, 20'h00003, 36'h123456789, 36'hABCDEF012, 4'b1111, 4'b1111);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_ld_n == 1'b0, "R3", "write load strobe", 64'(mem_ld_n), 0);
        chk(mem_rw == 1'b0, "R3", "write select", 64'(mem_rw), 0);
        chk(mem_addr == 20'h00003, "R3", "write address", 64'(mem_addr), 3);
        chk(mem_d_rise == 36'h123456789, "R4", "first beat", 64'(mem_d_rise), 64'h123456789);
        chk(mem_d_fall == 36'hABCDEF012, "R4", "second beat", 64'(mem_d_fall), 64'hABCDEF012);
        chk(mem_bw_rise_n == 4'b0000, "R5", "rise masks", 64'(mem_bw_rise_n), 0);
        @(negedge clk);
        chk(mem_bw_rise_n == 4'b1111 && mem_bw_fall_n == 4'b1111, "R5", "idle masks",
            64'({mem_bw_rise_n, mem_bw_fall_n}), 64'hFF);
    endtask

    task automatic t_read_pins();
        issue(1'b0, 20'h00003, '0, '0, '0, '0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_ld_n == 1'b0 && mem_rw == 1'b1, "R3", "read command",
            64'({mem_ld_n, mem_rw}), 64'h1);
        chk(mem_addr == 20'h00003, "R3", "read address", 64'(mem_addr), 3);
        drain();
    endtask

    task automatic t_partial_masks();
        issue(1'b1, 20'h00003, 36'h111111111, 36'h222222222, 4'b0101, 4'b1010);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_bw_rise_n == 4'b1010 && mem_bw_fall_n == 4'b0101, "R5", "per-beat masks",
            64'({mem_bw_rise_n, mem_bw_fall_n}), 64'hA5);
        issue(1'b1, 20'h00003, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 4'b0000, 4'b0000);
        issue(1'b0, 20'h00003, '0, '0, '0, '0);
        go_idle();
        drain();
    endtask

    task automatic t_back_to_back();
        issue(1'b1, 20'h00005, 36'h0A0A0A0A0, 36'h0B0B0B0B0, 4'b1111, 4'b1111);
        issue(1'b0, 20'h00005, '0, '0, '0, '0);
        issue(1'b1, 20'h00006, 36'h0C0C0C0C0, 36'h0D0D0D0D0, 4'b1100, 4'b0011);
        issue(1'b0, 20'h00006, '0, '0, '0, '0);
        issue(1'b0, 20'h00003, '0, '0, '0, '0);
        issue(1'b1, 20'h00005, 36'h777777777, 36'h888888888, 4'b1001, 4'b0110);
        issue(1'b0, 20'h00005, '0, '0, '0, '0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_ld_n == 1'b0 && mem_rw == 1'b1, "R6", "last of stream issued",
            64'({mem_ld_n, mem_rw}), 64'h1);
        drain();
    endtask

    task automatic t_reset_flush();
        issue(1'b0, 20'h00006, '0, '0, '0, '0);
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LAT + 3; i++) begin
            @(negedge clk);
            chk(rd_valid == 1'b0, "R8", "no result after reset", 64'(rd_valid), 0);
        end
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_write_pins();
        t_read_pins();
        t_partial_masks();
        t_back_to_back();
        t_reset_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule